// File: doc/BRIEF.md
# Multi-channel stream packet source for DMA ingress

This block sits between several independent producers and a DMA engine that takes data from card-side logic toward the host. Each producer hands the block a packet length in bytes and then supplies the packet's bytes packed into bus-wide words. For every channel the block turns that into a sequence of AXI4-Stream beats. It marks the final beat with tlast and builds a byte-enable mask that is full on every beat except the final one. It can also attach one parity bit per data byte on tuser.

Each channel has its own command port, its own word input and its own output stream. A channel's register stage holds a beat until the DMA side takes it, so backpressure on one stream never affects the others. Zero-length commands are consumed and dropped. Bus width, length width, channel count and parity propagation are parameters.

Top module: `dps_stream_source`

## Requirements
- R1: An output beat moves only on a cycle where tvalid and tready are both high; while tvalid is high and tready is low, tvalid stays high and tdata, tkeep, tlast and tuser do not change.
- R2: A packet of L bytes (L > 0) produces exactly ceil(L / BYTES) beats, where BYTES = DATA_W/8, and tlast is high on the last of them only.
- R3: Every beat without tlast has tkeep all ones.
- R4: On the tlast beat, tkeep bit i (covering tdata bits 8i+7..8i) is set exactly for i < ((L-1) mod BYTES) + 1, so the set bits form an unbroken run starting at bit 0.
- R5: With PARITY_EN = 1, tuser bit i is the XOR of the eight bits of byte i where tkeep bit i is set, and 0 where it is clear; with PARITY_EN = 0, tuser is all zeros.
- R6: A command with length 0 is accepted (cmd_ready high) and produces no output beat.
- R7: cmd_ready is high exactly when the channel holds no packet; it is low while a beat is pending, and it is high in the cycle after the tlast beat is taken.
- R8: During and right after reset, every tvalid and src_ready is low and every cmd_ready is high.
- R9: Holding tready low on one channel does not delay the beats of any other channel.
- R10: tdata on successive beats equals the source words in the order they were accepted on src_valid/src_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | NUM_CH | Per channel: a packet length is offered |
| cmd_len | input | NUM_CH*LEN_W | Per channel: packet length in bytes (channel c at bits c*LEN_W upward) |
| cmd_ready | output | NUM_CH | Per channel: idle, the offered length is taken |
| src_valid | input | NUM_CH | Per channel: a data word is offered |
| src_data | input | NUM_CH*DATA_W | Per channel: data word, byte 0 in the low bits |
| src_ready | output | NUM_CH | Per channel: the offered word is taken |
| c2h_tvalid | output | NUM_CH | Per channel stream: beat valid |
| c2h_tready | input | NUM_CH | Per channel stream: sink ready |
| c2h_tdata | output | NUM_CH*DATA_W | Per channel stream: beat data |
| c2h_tkeep | output | NUM_CH*DATA_W/8 | Per channel stream: byte enables |
| c2h_tlast | output | NUM_CH | Per channel stream: final beat of packet |
| c2h_tuser | output | NUM_CH*DATA_W/8 | Per channel stream: per-byte parity |

## Verification
The assertions check, every cycle and for each channel, that a stalled beat holds still, that a beat without tlast has a full mask, that the final mask is a gap-free run from bit 0, that no parity bit appears under a cleared byte enable, and that the command port is closed while a beat is pending and opens right after the final beat. The number of beats per packet, the exact mask width for a given length, the parity values, the word order, dropped zero-length commands and the independence of channels under a one-sided stall depend on the traffic. Only the bench's reference model, fed with mixed lengths and random stalls on both sides, can show those.

// File: rtl/dps_pkg.sv
package dps_pkg;
   typedef enum logic {
      CH_IDLE = 1'b0,
      CH_BUSY = 1'b1
   } ch_state_e;
endpackage

// File: rtl/dps_beat_fmt.sv
module dps_beat_fmt #(
   parameter int  DATA_W    = 64,
   parameter bit  PARITY_EN = 1'b1,
   localparam int BYTES     = DATA_W / 8,
   localparam int CNT_W     = $clog2(BYTES) + 1
) (
   input  logic              is_last,
   input  logic [CNT_W-1:0]  last_bytes,
   input  logic [DATA_W-1:0] data,
   output logic [BYTES-1:0]  keep,
   output logic [BYTES-1:0]  user
);
   for (genvar i = 0; i < BYTES; i++) begin : g_lane
      assign keep[i] = !is_last || (CNT_W'(i) < last_bytes);
      if (PARITY_EN) begin : g_par
         assign user[i] = keep[i] & (^data[8*i +: 8]);
      end else begin : g_nopar
         assign user[i] = 1'b0;
      end
   end
endmodule

// File: rtl/dps_channel.sv
module dps_channel
   import dps_pkg::*;
#(
   parameter int  DATA_W    = 64,
   parameter int  LEN_W     = 16,
   parameter bit  PARITY_EN = 1'b1,
   localparam int BYTES     = DATA_W / 8,
   localparam int BW        = $clog2(BYTES),
   localparam int CNT_W     = BW + 1,
   localparam int BEAT_W    = LEN_W - BW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [LEN_W-1:0]  cmd_len,
   output logic              cmd_ready,
   input  logic              src_valid,
   input  logic [DATA_W-1:0] src_data,
   output logic              src_ready,
   output logic              tvalid,
   input  logic              tready,
   output logic [DATA_W-1:0] tdata,
   output logic [BYTES-1:0]  tkeep,
   output logic              tlast,
   output logic [BYTES-1:0]  tuser
);
   ch_state_e           state;
   logic [BEAT_W-1:0]   fetch_left;
   logic [CNT_W-1:0]    last_bytes;
   logic                out_valid;
   logic                out_last;
   logic [DATA_W-1:0]   out_data;
   logic [BYTES-1:0]    fmt_keep;
   logic [BYTES-1:0]    fmt_user;
   logic [LEN_W:0]      len_round;
   logic [LEN_W-1:0]    len_m1;
   logic                slot_free;
   logic                load;
   logic                take_cmd;

   assign len_round = {1'b0, cmd_len} + (LEN_W + 1)'(BYTES - 1);
   assign len_m1    = cmd_len - LEN_W'(1);
   assign slot_free = !out_valid || tready;
   assign cmd_ready = (state == CH_IDLE);
   assign take_cmd  = cmd_ready && cmd_valid && (cmd_len != '0);
   assign src_ready = (state == CH_BUSY) && (fetch_left != '0) && slot_free;
   assign load      = src_ready && src_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= CH_IDLE;
         fetch_left <= '0;
         last_bytes <= '0;
      end else begin
         if (take_cmd) begin
            state      <= CH_BUSY;
            fetch_left <= len_round[LEN_W:BW];
            last_bytes <= {1'b0, len_m1[BW-1:0]} + CNT_W'(1);
         end else begin
            if (load) fetch_left <= fetch_left - BEAT_W'(1);
            if (out_valid && tready && out_last) state <= CH_IDLE;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_last  <= 1'b0;
         out_data  <= '0;
      end else if (load) begin
         out_valid <= 1'b1;
         out_last  <= (fetch_left == BEAT_W'(1));
         out_data  <= src_data;
      end else if (tready) begin
         out_valid <= 1'b0;
      end
   end

   dps_beat_fmt #(
      .DATA_W    (DATA_W),
      .PARITY_EN (PARITY_EN)
   ) u_fmt (
      .is_last    (out_last),
      .last_bytes (last_bytes),
      .data       (out_data),
      .keep       (fmt_keep),
      .user       (fmt_user)
   );

   assign tvalid = out_valid;
   assign tdata  = out_data;
   assign tlast  = out_valid && out_last;
   assign tkeep  = out_valid ? fmt_keep : '0;
   assign tuser  = out_valid ? fmt_user : '0;

   // R1
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tvalid && !tready) |=> (tvalid && $stable(tdata) && $stable(tkeep)
                               && $stable(tlast) && $stable(tuser)));
   // R3
   keep_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tvalid && !tlast) |-> (tkeep == '1));
   // R4
   keep_packed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tvalid && tlast) |-> (tkeep[0] && ((tkeep & (tkeep + BYTES'(1))) == '0)));
   // R5
   parity_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tuser & ~tkeep) == '0);
   // R7
   busy_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tvalid |-> !cmd_ready);
   // R7
   reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tvalid && tready && tlast) |=> cmd_ready);
endmodule

// File: rtl/dps_stream_source.sv
module dps_stream_source #(
   parameter int  NUM_CH    = 4,
   parameter int  DATA_W    = 64,
   parameter int  LEN_W     = 16,
   parameter bit  PARITY_EN = 1'b1,
   localparam int BYTES     = DATA_W / 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_CH-1:0]        cmd_valid,
   input  logic [NUM_CH*LEN_W-1:0]  cmd_len,
   output logic [NUM_CH-1:0]        cmd_ready,
   input  logic [NUM_CH-1:0]        src_valid,
   input  logic [NUM_CH*DATA_W-1:0] src_data,
   output logic [NUM_CH-1:0]        src_ready,
   output logic [NUM_CH-1:0]        c2h_tvalid,
   input  logic [NUM_CH-1:0]        c2h_tready,
   output logic [NUM_CH*DATA_W-1:0] c2h_tdata,
   output logic [NUM_CH*BYTES-1:0]  c2h_tkeep,
   output logic [NUM_CH-1:0]        c2h_tlast,
   output logic [NUM_CH*BYTES-1:0]  c2h_tuser
);
   if (NUM_CH < 1) begin : g_bad_ch
      $error("NUM_CH must be at least 1");
   end
   if (DATA_W < 16 || (DATA_W % 8) != 0) begin : g_bad_w
      $error("DATA_W must be a multiple of 8 and at least 16");
   end
   if ((BYTES & (BYTES - 1)) != 0) begin : g_bad_pow
      $error("DATA_W/8 must be a power of two");
   end
   if (LEN_W <= $clog2(BYTES)) begin : g_bad_len
      $error("LEN_W too small for the beat size");
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      dps_channel #(
         .DATA_W    (DATA_W),
         .LEN_W     (LEN_W),
         .PARITY_EN (PARITY_EN)
      ) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .cmd_valid (cmd_valid[c]),
         .cmd_len   (cmd_len[c*LEN_W +: LEN_W]),
         .cmd_ready (cmd_ready[c]),
         .src_valid (src_valid[c]),
         .src_data  (src_data[c*DATA_W +: DATA_W]),
         .src_ready (src_ready[c]),
         .tvalid    (c2h_tvalid[c]),
         .tready    (c2h_tready[c]),
         .tdata     (c2h_tdata[c*DATA_W +: DATA_W]),
         .tkeep     (c2h_tkeep[c*BYTES +: BYTES]),
         .tlast     (c2h_tlast[c]),
         .tuser     (c2h_tuser[c*BYTES +: BYTES])
      );
   end
endmodule

// File: tb/sim_dps_stream_source.sv
`timescale 1ns/1ps
module sim_dps_stream_source;
   localparam int NCH = 4;
   localparam int DW  = 64;
   localparam int LW  = 16;
   localparam int NB  = DW / 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [NCH-1:0]    cmd_valid;
   logic [NCH*LW-1:0] cmd_len;
   logic [NCH-1:0]    cmd_ready;
   logic [NCH-1:0]    src_valid;
   logic [NCH*DW-1:0] src_data;
   logic [NCH-1:0]    src_ready;
   logic [NCH-1:0]    tvalid;
   logic [NCH-1:0]    tready;
   logic [NCH*DW-1:0] tdata;
   logic [NCH*NB-1:0] tkeep;
   logic [NCH-1:0]    tlast;
   logic [NCH*NB-1:0] tuser;

   dps_stream_source #(.NUM_CH(NCH), .DATA_W(DW), .LEN_W(LW), .PARITY_EN(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_len(cmd_len), .cmd_ready(cmd_ready),
      .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
      .c2h_tvalid(tvalid), .c2h_tready(tready), .c2h_tdata(tdata),
      .c2h_tkeep(tkeep), .c2h_tlast(tlast), .c2h_tuser(tuser)
   );

   typedef struct packed {
      logic [DW-1:0] d;
      logic [NB-1:0] k;
      logic          l;
   } beat_t;

   beat_t         expq[NCH][$];
   logic [DW-1:0] srcq[NCH][$];
   int  checks = 0;
   int  errors = 0;
   int  done_cnt = 0;
   int  beats_seen[NCH];
   bit  stall3 = 1'b0;
   bit  prev_stall[NCH];
   bit  was_last[NCH];
   logic [DW+2*NB:0] prev_out[NCH];

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
      end
   endtask

   function automatic logic [NB-1:0] parity_of(input logic [DW-1:0] d, input logic [NB-1:0] k);
      logic [NB-1:0] p;
      for (int i = 0; i < NB; i++) p[i] = k[i] & (^d[8*i +: 8]);
      return p;
   endfunction

   // reference model, compared every cycle on the side away from the clock edge
   always @(negedge clk) begin
      if (rst_n) begin
         for (int c = 0; c < NCH; c++) begin
            logic [DW+2*NB:0] cur;
            cur = {tdata[c*DW +: DW], tkeep[c*NB +: NB], tuser[c*NB +: NB], tlast[c]};
            if (prev_stall[c])   // R1
               check(tvalid[c] && cur == prev_out[c], "R1", "stalled beat changed",
                     cur[63:0], prev_out[c][63:0]);
            prev_stall[c] = tvalid[c] && !tready[c];
            prev_out[c]   = cur;
            if (was_last[c]) begin   // R7
               check(cmd_ready[c] == 1'b1, "R7", "cmd_ready after tlast", 64'(cmd_ready[c]), 64'd1);
               was_last[c] = 1'b0;
            end
            if (tvalid[c])   // R7
               check(cmd_ready[c] == 1'b0, "R7", "cmd_ready while busy", 64'(cmd_ready[c]), 64'd0);
            if (tvalid[c] && tready[c]) begin
               if (expq[c].size() == 0) begin
                  check(1'b0, "R6", "unexpected beat", tdata[c*DW +: DW], 64'd0);
               end else begin
                  beat_t e;
                  e = expq[c].pop_front();
                  check(tdata[c*DW +: DW] == e.d, "R10", "tdata", tdata[c*DW +: DW], e.d);
                  check(tlast[c] == e.l, "R2", "tlast", 64'(tlast[c]), 64'(e.l));
                  if (e.l)
                     check(tkeep[c*NB +: NB] == e.k, "R4", "last tkeep", 64'(tkeep[c*NB +: NB]), 64'(e.k));
                  else
                     check(tkeep[c*NB +: NB] == e.k, "R3", "tkeep", 64'(tkeep[c*NB +: NB]), 64'(e.k));
                  check(tuser[c*NB +: NB] == parity_of(e.d, e.k), "R5", "tuser",
                        64'(tuser[c*NB +: NB]), 64'(parity_of(e.d, e.k)));
               end
               beats_seen[c]++;
               if (tlast[c]) was_last[c] = 1'b1;
            end
         end
      end
   end

   task automatic run_ch(input int cc);
      int lens[10] = '{1, 8, 9, 17, 0, 64, 3, 15, 16, 7};
      for (int p = 0; p < 20; p++) begin
         int len, nbeats, lb;
         len    = lens[(p + cc) % 10];
         nbeats = (len + NB - 1) / NB;
         lb     = (len > 0) ? ((len - 1) % NB) + 1 : 0;
         for (int b = 0; b < nbeats; b++) begin
            beat_t e;
            e.d = {$urandom, $urandom};
            e.l = (b == nbeats - 1);
            e.k = e.l ? NB'((16'h1 << lb) - 1) : '1;
            srcq[cc].push_back(e.d);
            expq[cc].push_back(e);
         end
         @(posedge clk); #1;
         cmd_valid[cc] = 1'b1;
         cmd_len[cc*LW +: LW] = LW'(len);
         do @(negedge clk); while (!cmd_ready[cc]);
         @(posedge clk); #1;
         cmd_valid[cc] = 1'b0;
         repeat ($urandom % 3) @(posedge clk);
      end
      while (expq[cc].size() != 0) @(negedge clk);
      done_cnt++;
   endtask

   task automatic feed(input int cc);
      forever begin
         bit take;
         @(negedge clk);
         take = src_valid[cc] && src_ready[cc];
         @(posedge clk); #1;
         if (take) void'(srcq[cc].pop_front());
         if (srcq[cc].size() > 0 && ($urandom % 4) != 0) begin
            src_valid[cc] = 1'b1;
            src_data[cc*DW +: DW] = srcq[cc][0];
         end else begin
            src_valid[cc] = 1'b0;
         end
      end
   endtask

   task automatic drive_ready(input int cc);
      forever begin
         @(posedge clk); #1;
         if (cc == 3 && stall3) tready[cc] = 1'b0;
         else tready[cc] = ($urandom % 3) != 0;
      end
   endtask

   task automatic finish_run;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", done_cnt, NCH);
      finish_run();
   end

   initial begin
      cmd_valid = '0; cmd_len = '0; src_valid = '0; src_data = '0; tready = '0;
      for (int c = 0; c < NCH; c++) begin
         beats_seen[c] = 0; prev_stall[c] = 0; was_last[c] = 0; prev_out[c] = '0;
      end
      repeat (3) @(posedge clk);
      #1;
      // R8
      check(tvalid == '0, "R8", "tvalid in reset", 64'(tvalid), 64'd0);
      check(cmd_ready == '1, "R8", "cmd_ready in reset", 64'(cmd_ready), 64'hF);
      rst_n = 1'b1;
      @(negedge clk);
      // R8
      check(tvalid == '0 && src_ready == '0, "R8", "after reset",
            64'({tvalid, src_ready}), 64'd0);
      stall3 = 1'b1;
      for (int c = 0; c < NCH; c++) begin
         automatic int cc = c;
         fork
            run_ch(cc);
            feed(cc);
            drive_ready(cc);
         join_none
      end
      repeat (300) @(negedge clk);
      // R9
      check(beats_seen[3] == 0, "R9", "stalled channel moved", 64'(beats_seen[3]), 64'd0);
      check(beats_seen[0] > 0 && beats_seen[1] > 0 && beats_seen[2] > 0, "R9",
            "other channels blocked", 64'(beats_seen[0]), 64'd1);
      check(tvalid[3] == 1'b1, "R1", "stalled beat not held", 64'(tvalid[3]), 64'd1);
      stall3 = 1'b0;
      while (done_cnt < NCH) @(negedge clk);
      // R6: lone zero-length command on channel 2
      @(posedge clk); #1;
      cmd_valid[2] = 1'b1;
      cmd_len[2*LW +: LW] = '0;
      @(negedge clk);
      check(cmd_ready[2] == 1'b1, "R6", "zero length not taken", 64'(cmd_ready[2]), 64'd1);
      @(posedge clk); #1;
      cmd_valid[2] = 1'b0;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         check(tvalid[2] == 1'b0 && cmd_ready[2] == 1'b1, "R6", "zero length made a beat",
               64'({tvalid[2], cmd_ready[2]}), 64'd1);
      end
      finish_run();
   end
endmodule